// File: doc/BRIEF.md
# Indexed Doubleword-Pair Vector Load Unit

This unit carries out one indexed vector load. It receives a 32-bit instruction word and checks both of its opcode fields. It reads two general-purpose registers through combinational read ports and adds their values to form the effective address. It then makes two 8-byte reads, one after the other, on a simple request/valid memory port. When both doublewords have returned, it writes the 128-bit result to one of 64 vector registers in a single cycle.

Each returned doubleword is either passed through unchanged or byte-reversed on its own, depending on the endian mode sampled when the instruction is accepted. The two halves are never exchanged. If the vector facility is disabled, or if the instruction word does not decode, the unit raises a one-cycle flag. In both cases it touches neither memory nor the register file.

Top module: `vld_dwpair_load`

## Requirements
- R1: An instruction is accepted only when `insn[31:26]` equals 31 and `insn[10:1]` equals 844. Any other word issued while idle raises `illegal` for exactly the cycle after acceptance and causes no memory request and no vector write.
- R2: The destination vector register is `vr_idx = 32*insn[0] + insn[25:21]`.
- R3: Address sources are `insn[20:16]` (A) and `insn[15:11]` (B), presented on `gpr_a_idx` and `gpr_b_idx`. The effective address is `gpr_b_data` when A is 0 and `gpr_a_data + gpr_b_data` otherwise, modulo 2^64. A zero B field still reads register 0.
- R4: If `vec_enable` is 0 when a valid load is issued, `vec_unavail` is high for the following cycle. No memory request and no vector write follow.
- R5: Exactly two one-cycle requests are made. The first is at EA. The second is at EA+8 (mod 2^64) and is issued only after the first read has returned.
- R6: In big-endian mode (`little_endian`=0), memory byte EA+8i+k becomes byte k of doubleword i. Byte 0 is the most significant. Doubleword 0 is `vr_wdata[127:64]`. Memory presents the byte at address a+k on `mem_rdata[63-8k -: 8]`.
- R7: In little-endian mode, memory byte EA+8i+k becomes byte 7-k of doubleword i. Each doubleword is reversed on its own and stays in its own half.
- R8: `vr_we` is high for exactly one cycle, after both reads have returned, and `done` is high in that same cycle. `busy` is high from the cycle after acceptance up to and including the write cycle, and low in the cycle after it.
- R9: An `issue_valid` presented while `busy` is high is ignored. It does not change the destination or the address of the load in flight.
- R10: After reset, `busy`, `done`, `mem_req`, `vr_we`, `illegal` and `vec_unavail` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| issue_valid | input | 1 | Instruction presented |
| insn | input | 32 | Instruction word |
| vec_enable | input | 1 | Vector facility enabled |
| little_endian | input | 1 | Byte order for this load |
| busy | output | 1 | Load in progress; new issues ignored |
| done | output | 1 | Completion pulse |
| illegal | output | 1 | Opcode mismatch pulse |
| vec_unavail | output | 1 | Vector-unavailable exception pulse |
| gpr_a_idx | output | 5 | Read index for address source A |
| gpr_a_data | input | 64 | Value of register A |
| gpr_b_idx | output | 5 | Read index for address source B |
| gpr_b_data | input | 64 | Value of register B |
| mem_req | output | 1 | Read request pulse |
| mem_addr | output | 64 | Read address |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | 64 | Read data, lowest address in the most significant byte |
| vr_we | output | 1 | Vector register write enable |
| vr_idx | output | 6 | Vector register index |
| vr_wdata | output | 128 | Vector register write data |

## Verification
The hardest situation to reach is a second read whose address wraps past the top of the 64-bit space. Reaching it needs register values that sum to within 8 of 2^64. The stimulus table therefore includes operand pairs near the top of the address range, so that one load straddles the wrap and another starts beyond it. The other hard case is a fresh issue arriving while a load is waiting on memory. A directed test holds `issue_valid` high with a different instruction while the responder stalls each read for several cycles, and the bench then confirms that only the first instruction completes.

// File: rtl/vld_pkg.sv
package vld_pkg;
  localparam int unsigned INSN_W   = 32;
  localparam int unsigned GPR_SEL_W = 5;
  localparam int unsigned VR_SEL_W  = 6;
  localparam logic [5:0]  OPC_MAJOR = 6'd31;
  localparam logic [9:0]  OPC_MINOR = 10'd844;

  typedef struct packed {
    logic                 match;
    logic [4:0]           t_lo;
    logic                 t_hi;
    logic [GPR_SEL_W-1:0] src_a;
    logic [GPR_SEL_W-1:0] src_b;
  } vld_dec_t;

  typedef enum logic [2:0] {
    S_IDLE  = 3'd0,
    S_REQ0  = 3'd1,
    S_WAIT0 = 3'd2,
    S_REQ1  = 3'd3,
    S_WAIT1 = 3'd4,
    S_WRITE = 3'd5
  } vld_state_e;
endpackage

// File: rtl/vld_rst_sync.sv
module vld_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n_in,
  output logic rst_n_out
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n_in) begin
    if (!rst_n_in) sync_q <= '0;
    else           sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_out = sync_q[STAGES-1];
endmodule

// File: rtl/vld_decode.sv
module vld_decode
  import vld_pkg::*;
(
  input  logic [INSN_W-1:0] insn,
  output vld_dec_t          dec
);
  logic [5:0] major;
  logic [9:0] minor;

  always_comb begin
    major     = insn[31:26];
    minor     = insn[10:1];
    dec.match = (major == OPC_MAJOR) && (minor == OPC_MINOR);
    dec.t_lo  = insn[25:21];
    dec.src_a = insn[20:16];
    dec.src_b = insn[15:11];
    dec.t_hi  = insn[0];
  end
endmodule

// File: rtl/vld_agen.sv
module vld_agen #(
  parameter int unsigned ADDR_W = 64
) (
  input  logic              a_is_zero,
  input  logic [ADDR_W-1:0] a_val,
  input  logic [ADDR_W-1:0] b_val,
  output logic [ADDR_W-1:0] ea
);
  logic [ADDR_W-1:0] base;

  always_comb begin
    base = a_is_zero ? '0 : a_val;
    ea   = base + b_val;
  end
endmodule

// File: rtl/vld_lane_steer.sv
module vld_lane_steer #(
  parameter int unsigned DATA_W = 64
) (
  input  logic              rev,
  input  logic [DATA_W-1:0] din,
  output logic [DATA_W-1:0] dout
);
  localparam int unsigned NBYTES = DATA_W / 8;

  for (genvar k = 0; k < NBYTES; k++) begin : g_lane
    assign dout[8*k +: 8] = rev ? din[8*(NBYTES-1-k) +: 8] : din[8*k +: 8];
  end
endmodule

// File: rtl/vld_dwpair_load.sv
module vld_dwpair_load
  import vld_pkg::*;
#(
  parameter int unsigned ADDR_W = 64,
  parameter int unsigned DATA_W = 64
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    issue_valid,
  input  logic [INSN_W-1:0]       insn,
  input  logic                    vec_enable,
  input  logic                    little_endian,
  output logic                    busy,
  output logic                    done,
  output logic                    illegal,
  output logic                    vec_unavail,
  output logic [GPR_SEL_W-1:0]    gpr_a_idx,
  input  logic [ADDR_W-1:0]       gpr_a_data,
  output logic [GPR_SEL_W-1:0]    gpr_b_idx,
  input  logic [ADDR_W-1:0]       gpr_b_data,
  output logic                    mem_req,
  output logic [ADDR_W-1:0]       mem_addr,
  input  logic                    mem_rvalid,
  input  logic [DATA_W-1:0]       mem_rdata,
  output logic                    vr_we,
  output logic [VR_SEL_W-1:0]     vr_idx,
  output logic [2*DATA_W-1:0]     vr_wdata
);
  localparam logic [ADDR_W-1:0] STEP = ADDR_W'(DATA_W / 8);

  logic rst_n_s;
  vld_rst_sync #(.STAGES(2)) u_rst (.clk(clk), .rst_n_in(rst_n), .rst_n_out(rst_n_s));

  vld_dec_t          dec;
  logic [ADDR_W-1:0] ea_calc;
  logic [DATA_W-1:0] steered;

  vld_decode u_dec (.insn(insn), .dec(dec));

  vld_agen #(.ADDR_W(ADDR_W)) u_agen (
    .a_is_zero(dec.src_a == '0),
    .a_val    (gpr_a_data),
    .b_val    (gpr_b_data),
    .ea       (ea_calc)
  );

  vld_state_e          state_q, state_d;
  logic [ADDR_W-1:0]   ea_q, ea_d;
  logic                le_q, le_d;
  logic [VR_SEL_W-1:0] tgt_q, tgt_d;
  logic [DATA_W-1:0]   dw0_q, dw0_d, dw1_q, dw1_d;
  logic                ill_q, ill_d, unav_q, unav_d;
  logic                accept;
  logic                cap_en;

  vld_lane_steer #(.DATA_W(DATA_W)) u_steer (.rev(le_q), .din(mem_rdata), .dout(steered));

  assign accept = issue_valid && (state_q == S_IDLE);

  always_comb begin
    state_d = state_q;
    ea_d    = ea_q;
    le_d    = le_q;
    tgt_d   = tgt_q;
    dw0_d   = dw0_q;
    dw1_d   = dw1_q;
    ill_d   = 1'b0;
    unav_d  = 1'b0;
    cap_en  = 1'b0;
    unique case (state_q)
      S_IDLE: begin
        if (accept) begin
          if (!dec.match) begin
            ill_d = 1'b1;
          end else if (!vec_enable) begin
            unav_d = 1'b1;
          end else begin
            cap_en  = 1'b1;
            ea_d    = ea_calc;
            le_d    = little_endian;
            tgt_d   = {dec.t_hi, dec.t_lo};
            state_d = S_REQ0;
          end
        end
      end
      S_REQ0:  state_d = S_WAIT0;
      S_WAIT0: begin
        if (mem_rvalid) begin
          dw0_d   = steered;
          state_d = S_REQ1;
        end
      end
      S_REQ1:  state_d = S_WAIT1;
      S_WAIT1: begin
        if (mem_rvalid) begin
          dw1_d   = steered;
          state_d = S_WRITE;
        end
      end
      S_WRITE: state_d = S_IDLE;
      default: state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      state_q <= S_IDLE;
      ill_q   <= 1'b0;
      unav_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      ill_q   <= ill_d;
      unav_q  <= unav_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      ea_q  <= '0;
      le_q  <= 1'b0;
      tgt_q <= '0;
    end else if (cap_en) begin
      ea_q  <= ea_d;
      le_q  <= le_d;
      tgt_q <= tgt_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      dw0_q <= '0;
      dw1_q <= '0;
    end else if (mem_rvalid) begin
      dw0_q <= dw0_d;
      dw1_q <= dw1_d;
    end
  end

  assign gpr_a_idx   = dec.src_a;
  assign gpr_b_idx   = dec.src_b;
  assign busy        = (state_q != S_IDLE);
  assign done        = (state_q == S_WRITE);
  assign vr_we       = (state_q == S_WRITE);
  assign illegal     = ill_q;
  assign vec_unavail = unav_q;
  assign mem_req     = (state_q == S_REQ0) || (state_q == S_REQ1);
  assign mem_addr    = (state_q == S_REQ1) ? ea_q + STEP : ea_q;
  assign vr_idx      = tgt_q;
  assign vr_wdata    = {dw0_q, dw1_q};
endmodule

// File: rtl/vld_dwpair_load_chk.sv
module vld_dwpair_load_chk #(
  parameter int unsigned ADDR_W = 64,
  parameter int unsigned DATA_W = 64
) (
  input logic              clk,
  input logic              rst_n,
  input logic              busy,
  input logic              done,
  input logic              illegal,
  input logic              vec_unavail,
  input logic              mem_req,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              mem_rvalid,
  input logic              vr_we
);
  localparam logic [ADDR_W-1:0] STEP = ADDR_W'(DATA_W / 8);

  logic [1:0]        req_cnt, rv_cnt;
  logic [ADDR_W-1:0] first_addr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_cnt    <= '0;
      rv_cnt     <= '0;
      first_addr <= '0;
    end else if (vr_we) begin
      req_cnt <= '0;
      rv_cnt  <= '0;
    end else begin
      if (mem_req) begin
        req_cnt <= req_cnt + 2'd1;
        if (req_cnt == 2'd0) first_addr <= mem_addr;
      end
      if (mem_rvalid && busy) rv_cnt <= rv_cnt + 2'd1;
    end
  end

  p_ill_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    illegal |-> (!mem_req && !vr_we && !busy));

  p_unav_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
    vec_unavail |-> (!mem_req && !vr_we && !busy));

  p_req_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |=> !mem_req);

  p_second_addr_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && req_cnt == 2'd1) |-> (mem_addr == first_addr + STEP));

  p_second_after_first_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && req_cnt == 2'd1) |-> (rv_cnt == 2'd1));

  p_write_after_both_r8: assert property (@(posedge clk) disable iff (!rst_n)
    vr_we |-> (req_cnt == 2'd2 && rv_cnt == 2'd2 && done && busy));

  p_done_ends_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (!busy && !vr_we));
endmodule

bind vld_dwpair_load vld_dwpair_load_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .busy       (busy),
  .done       (done),
  .illegal    (illegal),
  .vec_unavail(vec_unavail),
  .mem_req    (mem_req),
  .mem_addr   (mem_addr),
  .mem_rvalid (mem_rvalid),
  .vr_we      (vr_we)
);

// File: tb/sim_vld_dwpair_load.sv
`timescale 1ns/1ps
module sim_vld_dwpair_load;
  logic         clk = 1'b0;
  logic         rst_n;
  logic         issue_valid;
  logic [31:0]  insn;
  logic         vec_enable;
  logic         little_endian;
  logic         busy, done, illegal, vec_unavail;
  logic [4:0]   gpr_a_idx, gpr_b_idx;
  logic [63:0]  gpr_a_data, gpr_b_data;
  logic         mem_req;
  logic [63:0]  mem_addr;
  logic         mem_rvalid;
  logic [63:0]  mem_rdata;
  logic         vr_we;
  logic [5:0]   vr_idx;
  logic [127:0] vr_wdata;

  logic [63:0] gpr [32];
  int n_run = 0;
  int n_fail = 0;
  int lat = 1;
  int req_cnt = 0;
  int pend = 0;
  int cnt = 0;
  int overlap = 0;
  int wr_cnt = 0;
  logic [63:0] addr_log [2];
  logic [63:0] pend_addr;

  always #2 clk = ~clk;

  assign gpr_a_data = gpr[gpr_a_idx];
  assign gpr_b_data = gpr[gpr_b_idx];

  vld_dwpair_load u0 (.*);

  function automatic logic [7:0] mb(input logic [63:0] a);
    return a[7:0] ^ {a[11:8], a[15:12]} ^ a[63:56] ^ 8'h3C;
  endfunction

  function automatic logic [63:0] mem_dw(input logic [63:0] a);
    logic [63:0] r;
    for (int k = 0; k < 8; k++) r[63-8*k -: 8] = mb(a + 64'(k));
    return r;
  endfunction

  function automatic logic [63:0] exp_dw(input logic [63:0] a, input logic le);
    logic [63:0] r;
    for (int k = 0; k < 8; k++) begin
      if (le) r[8*k+7 -: 8] = mb(a + 64'(k));
      else    r[63-8*k -: 8] = mb(a + 64'(k));
    end
    return r;
  endfunction

  function automatic logic [31:0] mk(input logic [4:0] t, input logic tx,
                                     input logic [4:0] a, input logic [4:0] b,
                                     input logic [5:0] op, input logic [9:0] xo);
    return {op, t, a, b, xo, tx};
  endfunction

  // memory responder
  always @(negedge clk) begin
    mem_rvalid <= 1'b0;
    if (pend != 0) begin
      if (cnt == 0) begin
        mem_rvalid <= 1'b1;
        mem_rdata  <= mem_dw(pend_addr);
        pend = 0;
      end else cnt = cnt - 1;
    end
    if (rst_n && mem_req) begin
      if (pend != 0) overlap++;
      if (req_cnt < 2) addr_log[req_cnt] = mem_addr;
      req_cnt++;
      pend = 1;
      cnt = lat - 1;
      pend_addr = mem_addr;
    end
    if (rst_n && vr_we) wr_cnt++;
  end

  // watchdog
  int wd = 0;
  always @(posedge clk) begin
    wd++;
    if (wd > 20000) begin
      n_fail++;
      $display("FAIL watchdog expired act=%0d exp=<20000", wd);
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [127:0] act, input logic [127:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic clr();
    req_cnt = 0; overlap = 0; wr_cnt = 0;
    addr_log[0] = '0; addr_log[1] = '0;
  endtask

  task automatic issue(input logic [31:0] w, input logic en, input logic le);
    @(posedge clk); #1;
    clr();
    insn = w; vec_enable = en; little_endian = le; issue_valid = 1'b1;
    @(posedge clk); #1;
    issue_valid = 1'b0;
  endtask

  task automatic run_load(input logic [31:0] w, input logic le, input logic [63:0] ea,
                          input logic [5:0] tgt, input string tag);
    bit seen = 0;
    issue(w, 1'b1, le);
    for (int i = 0; i < 60 && !seen; i++) begin
      @(negedge clk); #1;
      if (vr_we) seen = 1;
    end
    chk(seen, {tag, " R8 write seen"}, 128'(seen), 128'd1);
    chk(done && busy, {tag, " R8 done with write"}, {done, busy}, 2'b11);
    chk(vr_idx == tgt, {tag, " R2 target"}, 128'(vr_idx), 128'(tgt));
    chk(vr_wdata == {exp_dw(ea, le), exp_dw(ea + 64'd8, le)},
        le ? {tag, " R7 little-endian data"} : {tag, " R6 big-endian data"},
        vr_wdata, {exp_dw(ea, le), exp_dw(ea + 64'd8, le)});
    chk(addr_log[0] == ea, {tag, " R3 effective address"}, 128'(addr_log[0]), 128'(ea));
    chk(addr_log[1] == ea + 64'd8 && req_cnt == 2 && overlap == 0, {tag, " R5 second read"},
        {addr_log[1], 32'(req_cnt), 32'(overlap)}, {ea + 64'd8, 32'd2, 32'd0});
    @(negedge clk); #1;
    chk(!busy && !vr_we && wr_cnt == 1, {tag, " R8 single write then idle"},
        {busy, vr_we, 32'(wr_cnt)}, {2'b00, 32'd1});
  endtask

  localparam int NV = 6;
  localparam logic [4:0]  V_T   [NV] = '{5'd3, 5'd31, 5'd0, 5'd17, 5'd8, 5'd22};
  localparam logic        V_TX  [NV] = '{1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0};
  localparam logic [4:0]  V_A   [NV] = '{5'd4, 5'd0, 5'd9, 5'd2, 5'd1, 5'd6};
  localparam logic [4:0]  V_B   [NV] = '{5'd5, 5'd7, 5'd9, 5'd0, 5'd3, 5'd8};
  localparam logic        V_LE  [NV] = '{1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0};
  localparam logic [63:0] V_AV  [NV] = '{64'h1000, 64'h0, 64'h4008, 64'h100,
                                         64'hFFFF_FFFF_FFFF_FFF8, 64'hFFFF_FFFF_FFFF_FFF0};
  localparam logic [63:0] V_BV  [NV] = '{64'h20, 64'h2000, 64'h4008, 64'hDEAD_0000,
                                         64'h0, 64'h14};
  localparam logic [63:0] V_EA  [NV] = '{64'h1020, 64'h2000, 64'h8010, 64'hDEAD_0100,
                                         64'hFFFF_FFFF_FFFF_FFF8, 64'h4};
  localparam int          V_LAT [NV] = '{1, 2, 3, 1, 2, 3};

  initial begin
    rst_n = 1'b0; issue_valid = 1'b0; insn = '0; vec_enable = 1'b1; little_endian = 1'b0;
    for (int i = 0; i < 32; i++) gpr[i] = 64'h0101_0101_0000_0000 * 64'(i + 1);
    gpr[0] = 64'hDEAD_0000;
    repeat (4) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk); #1;
    // R10 reset state
    chk({busy, done, mem_req, vr_we, illegal, vec_unavail} == 6'b0, "R10 reset outputs",
        128'({busy, done, mem_req, vr_we, illegal, vec_unavail}), 128'd0);

    for (int v = 0; v < NV; v++) begin
      if (V_A[v] != 5'd0) gpr[V_A[v]] = V_AV[v];
      if (V_B[v] != 5'd0) gpr[V_B[v]] = V_BV[v];
      lat = V_LAT[v];
      run_load(mk(V_T[v], V_TX[v], V_A[v], V_B[v], 6'd31, 10'd844), V_LE[v], V_EA[v],
               {V_TX[v], V_T[v]}, $sformatf("vec%0d", v));
    end

    // R1 wrong primary opcode
    issue(mk(5'd1, 1'b0, 5'd4, 5'd5, 6'd30, 10'd844), 1'b1, 1'b0);
    @(negedge clk); #1;
    chk(illegal && !busy, "R1 bad major flagged", {illegal, busy}, 2'b10);
    repeat (6) @(negedge clk); #1;
    chk(!illegal && req_cnt == 0 && wr_cnt == 0, "R1 bad major no side effects",
        {illegal, 32'(req_cnt), 32'(wr_cnt)}, 65'd0);

    // R1 wrong extended opcode
    issue(mk(5'd1, 1'b0, 5'd4, 5'd5, 6'd31, 10'd845), 1'b1, 1'b0);
    @(negedge clk); #1;
    chk(illegal && !vec_unavail, "R1 bad minor flagged", {illegal, vec_unavail}, 2'b10);
    repeat (6) @(negedge clk); #1;
    chk(req_cnt == 0 && wr_cnt == 0, "R1 bad minor no side effects",
        {32'(req_cnt), 32'(wr_cnt)}, 64'd0);

    // R4 facility disabled
    issue(mk(5'd2, 1'b1, 5'd4, 5'd5, 6'd31, 10'd844), 1'b0, 1'b0);
    @(negedge clk); #1;
    chk(vec_unavail && !illegal && !busy, "R4 unavailable flagged",
        {vec_unavail, illegal, busy}, 3'b100);
    repeat (6) @(negedge clk); #1;
    chk(req_cnt == 0 && wr_cnt == 0 && !vec_unavail, "R4 no access or write",
        {vec_unavail, 32'(req_cnt), 32'(wr_cnt)}, 65'd0);

    // R9 issue while busy is ignored
    lat = 3;
    gpr[4] = 64'h3000; gpr[5] = 64'h18;
    @(posedge clk); #1;
    clr();
    insn = mk(5'd12, 1'b1, 5'd4, 5'd5, 6'd31, 10'd844); little_endian = 1'b0;
    vec_enable = 1'b1; issue_valid = 1'b1;
    @(posedge clk); #1;
    insn = mk(5'd5, 1'b0, 5'd9, 5'd9, 6'd31, 10'd844); little_endian = 1'b1;
    repeat (3) @(posedge clk);
    #1 issue_valid = 1'b0;
    begin
      bit seen = 0;
      for (int i = 0; i < 60 && !seen; i++) begin
        @(negedge clk); #1;
        if (vr_we) seen = 1;
      end
      chk(seen && vr_idx == 6'd44, "R9 in-flight target kept", 128'(vr_idx), 128'd44);
      chk(vr_wdata == {exp_dw(64'h3018, 1'b0), exp_dw(64'h3020, 1'b0)},
          "R9 in-flight data kept", vr_wdata,
          {exp_dw(64'h3018, 1'b0), exp_dw(64'h3020, 1'b0)});
    end
    repeat (8) @(negedge clk); #1;
    chk(req_cnt == 2 && wr_cnt == 1 && !busy, "R9 busy issue dropped",
        {32'(req_cnt), 32'(wr_cnt)}, {32'd2, 32'd1});

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule